// File: doc/BRIEF.md
# Dual-Slope Integration Sequencer

This block holds the digital half of a dual-slope analog-to-digital converter. After a start pulse it clears the external integrator for a set number of clock cycles. It then routes the unknown input into the integrator for exactly 2^N cycles. Next it routes the negative reference in and counts clock cycles until the zero-crossing comparator reports that the integrator has returned to zero. That count is the conversion result. The input voltage follows from the count as Vin = Vref × count / 2^N.

The integrator, the analog switches and the comparator sit outside the block. The block drives a two-bit switch select and an integrator clear line, and it reads one comparator bit. The result is one bit wider than the resolution. A de-integration that runs for 2^N cycles without a crossing ends the conversion: the block saturates the result and raises an overrange flag. A one-cycle done pulse marks each finished conversion.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, sel_o is 2'b00 (ground), int_rst_o, done_o and ovr_o are low, and result_o is zero.
- R2: A start pulse while idle raises int_rst_o for exactly CLR_CYCLES consecutive cycles, with sel_o at 2'b00 (ground) throughout, before anything else happens.
- R3: The clear phase is followed directly by exactly 2^RES_BITS consecutive cycles with sel_o at 2'b01 (input).
- R4: The input phase is followed directly, with no gap, by sel_o at 2'b10 (negative reference), which holds until the conversion ends.
- R5: In range, result_o is the number of negative-reference cycles that come before the first such cycle in which cmp_zero_i is high. A crossing in the first such cycle gives 0. Such a result has bit RES_BITS clear and ovr_o low.
- R6: If cmp_zero_i stays low for all 2^RES_BITS negative-reference cycles, result_o becomes 2^RES_BITS (only bit RES_BITS set) and ovr_o goes high.
- R7: done_o is high for exactly one cycle, the cycle after the last negative-reference cycle. In that cycle sel_o is already back at ground.
- R8: A start pulse during a conversion is ignored. The phase lengths and the result are the same as without it.
- R9: sel_o never takes the value 2'b11, so the input and the reference are never connected together.
- R10: result_o and ovr_o change only when done_o is high. They hold their values while idle, and an in-range result clears an earlier overrange flag.
- R11: cmp_zero_i is ignored outside the negative-reference phase. A comparator that reads high during the clear phase and the start of the input phase does not shorten the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a conversion when sampled high while idle |
| cmp_zero_i | input | 1 | Comparator output, high when the integrator is at or below zero |
| sel_o | output | 2 | Switch select: 00 ground, 01 input, 10 negative reference |
| int_rst_o | output | 1 | Integrator clear |
| result_o | output | RES_BITS+1 | De-integration count, saturated at 2^RES_BITS |
| done_o | output | 1 | One-cycle pulse when a conversion finishes |
| ovr_o | output | 1 | Overrange flag of the last conversion |

## Verification
The hardest state to reach from the ports is saturation. The de-integration count has to reach its final value without a crossing, so the integrated charge must reach or exceed a full-scale count. The bench models the integrator numerically from sel_o and feeds back the comparator. It applies an input equal to the reference, and one well above it, so the count runs out in the last allowed cycle. It also uses a reference three times larger to produce a rounded-up count. The comparator reads high from the integrator reset until the first input cycle, which exercises R11 on every conversion.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

    typedef enum logic [1:0] {
        SW_GND  = 2'b00,
        SW_VIN  = 2'b01,
        SW_NREF = 2'b10
    } sw_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_CLR   = 2'b01,
        PH_INT   = 2'b10,
        PH_DEINT = 2'b11
    } phase_e;

    typedef struct packed {
        sw_sel_e sel;
        logic    clr;
    } sw_ctrl_t;

    function automatic sw_ctrl_t phase_to_switch(phase_e p);
        sw_ctrl_t c;
        c.clr = 1'b0;
        c.sel = SW_GND;
        case (p)
            PH_CLR:   c.clr = 1'b1;
            PH_INT:   c.sel = SW_VIN;
            PH_DEINT: c.sel = SW_NREF;
            default:  c.sel = SW_GND;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsi_phase_ctrl.sv
module dsi_phase_ctrl
    import dsi_pkg::*;
#(
    parameter int RES_BITS   = 8,
    parameter int CLR_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   deint_end_i,
    output phase_e phase_o
);
    localparam int T1     = 1 << RES_BITS;
    localparam int LONGER = (T1 > CLR_CYCLES) ? T1 : CLR_CYCLES;
    localparam int TW     = $clog2(LONGER + 1);
    localparam logic [TW-1:0] CLR_LAST = TW'(CLR_CYCLES - 1);
    localparam logic [TW-1:0] INT_LAST = TW'(T1 - 1);

    phase_e        ph;
    logic [TW-1:0] tmr;

    // start_i is looked at only in PH_IDLE (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            tmr <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    tmr <= '0;
                    if (start_i) ph <= PH_CLR;
                end
                PH_CLR: begin
                    if (tmr == CLR_LAST) begin
                        ph  <= PH_INT;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                PH_INT: begin
                    if (tmr == INT_LAST) begin
                        ph  <= PH_DEINT;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                PH_DEINT: begin
                    if (deint_end_i) ph <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = ph;
endmodule

// File: rtl/dsi_t2_counter.sv
module dsi_t2_counter
    import dsi_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  phase_e              phase_i,
    input  logic                cmp_zero_i,
    output logic                end_o,
    output logic [RES_BITS:0]   result_o,
    output logic                done_o,
    output logic                ovr_o
);
    localparam logic [RES_BITS-1:0] CNT_MAX = '1;
    localparam logic [RES_BITS:0]   SAT_VAL = (RES_BITS+1)'(1) << RES_BITS;

    logic [RES_BITS-1:0] cnt;
    logic                in_deint;
    logic                hit;
    logic                runout;

    assign in_deint = (phase_i == PH_DEINT);
    assign hit      = in_deint && cmp_zero_i;              // R11: gated by phase
    assign runout   = in_deint && !cmp_zero_i && (cnt == CNT_MAX);
    assign end_o    = hit || runout;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            result_o <= '0;
            done_o   <= 1'b0;
            ovr_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!in_deint) begin
                cnt <= '0;
            end else if (hit) begin
                result_o <= {1'b0, cnt};      // R5
                ovr_o    <= 1'b0;
                done_o   <= 1'b1;
            end else if (runout) begin
                result_o <= SAT_VAL;          // R6
                ovr_o    <= 1'b1;
                done_o   <= 1'b1;
            end else begin
                cnt <= cnt + RES_BITS'(1);
            end
        end
    end
endmodule

// File: rtl/dsi_switch_drive.sv
module dsi_switch_drive
    import dsi_pkg::*;
(
    input  phase_e      phase_i,
    output logic [1:0]  sel_o,
    output logic        int_rst_o
);
    sw_ctrl_t ctl;

    always_comb begin
        ctl       = phase_to_switch(phase_i);
        sel_o     = ctl.sel;
        int_rst_o = ctl.clr;
    end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsi_pkg::*;
#(
    parameter int RES_BITS   = 8,
    parameter int CLR_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                cmp_zero_i,
    output logic [1:0]          sel_o,
    output logic                int_rst_o,
    output logic [RES_BITS:0]   result_o,
    output logic                done_o,
    output logic                ovr_o
);
    phase_e phase;
    logic   deint_end;

    dsi_phase_ctrl #(
        .RES_BITS   (RES_BITS),
        .CLR_CYCLES (CLR_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .deint_end_i (deint_end),
        .phase_o     (phase)
    );

    dsi_t2_counter #(
        .RES_BITS (RES_BITS)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .phase_i    (phase),
        .cmp_zero_i (cmp_zero_i),
        .end_o      (deint_end),
        .result_o   (result_o),
        .done_o     (done_o),
        .ovr_o      (ovr_o)
    );

    dsi_switch_drive u_sw (
        .phase_i   (phase),
        .sel_o     (sel_o),
        .int_rst_o (int_rst_o)
    );
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
    parameter int RES_BITS   = 8,
    parameter int CLR_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        sel_o,
    input logic              int_rst_o,
    input logic [RES_BITS:0] result_o,
    input logic              done_o,
    input logic              ovr_o
);
    localparam int T1 = 1 << RES_BITS;
    localparam logic [RES_BITS+1:0] T1_W = (RES_BITS+2)'(T1);
    localparam logic [RES_BITS:0]   SAT  = (RES_BITS+1)'(1) << RES_BITS;

    logic [RES_BITS+1:0] vin_run;

    always_ff @(posedge clk) begin
        if (rst)                vin_run <= '0;
        else if (sel_o == 2'b01) vin_run <= vin_run + (RES_BITS+2)'(1);
        else                    vin_run <= '0;
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sel_o != 2'b11);                                                    // R9
    AST_CLR_ON_GND: assert property (@(posedge clk) disable iff (rst)
        int_rst_o |-> sel_o == 2'b00);                                      // R2
    AST_INT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (sel_o != 2'b01 && vin_run != '0) |-> vin_run == T1_W);             // R3
    AST_INT_TO_NREF: assert property (@(posedge clk) disable iff (rst)
        sel_o == 2'b01 |=> (sel_o == 2'b01 || sel_o == 2'b10));             // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                                // R7
    AST_DONE_ON_GND: assert property (@(posedge clk) disable iff (rst)
        done_o |-> sel_o == 2'b00);                                         // R7
    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovr_o) |-> result_o == SAT);                             // R6
    AST_INRANGE_MSB: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovr_o) |-> !result_o[RES_BITS]);                        // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));                 // R10
endmodule

bind dual_slope_seq dual_slope_seq_chk #(
    .RES_BITS   (RES_BITS),
    .CLR_CYCLES (CLR_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_o     (sel_o),
    .int_rst_o (int_rst_o),
    .result_o  (result_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
);

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RB         = 8;
    localparam int CLRN       = 4;
    localparam int T1         = 1 << RB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          cmp_zero_i;
    logic [1:0]    sel_o;
    logic          int_rst_o;
    logic [RB:0]   result_o;
    logic          done_o;
    logic          ovr_o;

    int checks = 0;
    int fails  = 0;

    // Numerical integrator model driven by the switch select
    longint integ = 0;
    longint ain   = 0;
    longint vref  = T1;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (int_rst_o)             integ <= 0;
        else if (sel_o == 2'b01)   integ <= integ + ain;
        else if (sel_o == 2'b10)   integ <= integ - vref;
    end
    assign cmp_zero_i = (integ <= 0);

    dual_slope_seq #(.RES_BITS(RB), .CLR_CYCLES(CLRN)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmp_zero_i (cmp_zero_i),
        .sel_o      (sel_o),
        .int_rst_o  (int_rst_o),
        .result_o   (result_o),
        .done_o     (done_o),
        .ovr_o      (ovr_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(sel_o == 2'b00, "R1", "sel after reset", sel_o, 0);
        chk(!int_rst_o && !done_o && !ovr_o, "R1", "flags after reset",
            {int_rst_o, done_o, ovr_o}, 0);
        chk(result_o == 0, "R1", "result after reset", result_o, 0);
    endtask

    // One full conversion; restart != 0 pulses start during integration (R8)
    task automatic t_convert(input longint a, input longint r, input bit restart);
        longint exp_t2;
        bit     exp_ovr;
        int     n_clr = 0, n_int = 0, n_de = 0, cyc = 0;
        bit     gap = 0, clr_gap = 0, seen_int = 0;
        logic [1:0] prev = 2'b00;
        ain  = a;
        vref = r;
        exp_t2  = (a * T1 + r - 1) / r;
        exp_ovr = (exp_t2 >= T1);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 5000) begin
            if (int_rst_o) begin
                n_clr++;
                if (sel_o != 2'b00) clr_gap = 1;
            end
            if (sel_o == 2'b01) begin
                n_int++;
                seen_int = 1;
                if (n_clr != CLRN) clr_gap = 1;
            end
            if (sel_o == 2'b10) begin
                n_de++;
                if (prev != 2'b01 && prev != 2'b10) gap = 1;
            end
            if (sel_o == 2'b00 && seen_int) gap = 1;
            if (restart && n_int == 10) start_i = 1'b1;
            else start_i = 1'b0;
            prev = sel_o;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cyc < 5000, "R7", "done seen", cyc, 0);
        chk(n_clr == CLRN && !clr_gap, "R2", "clear phase length", n_clr, CLRN);
        chk(n_int == T1, "R3", "input phase length", n_int, T1);
        chk(!gap, "R4", "input to reference without gap", gap, 0);
        if (exp_ovr) begin
            chk(n_de == T1, "R6", "reference cycles", n_de, T1);
            chk(result_o == (1 << RB), "R6", "saturated result", result_o, 1 << RB);
            chk(ovr_o == 1'b1, "R6", "overrange flag", ovr_o, 1);
        end else begin
            chk(n_de == exp_t2 + 1, "R5", "reference cycles", n_de, exp_t2 + 1);
            chk(result_o == exp_t2, "R5", "result", result_o, exp_t2);
            chk(ovr_o == 1'b0, "R5", "no overrange", ovr_o, 0);
        end
        chk(sel_o == 2'b00, "R7", "sel at done", sel_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
        chk(sel_o == 2'b00 && !int_rst_o, "R8", "idle after done, no restart",
            sel_o, 0);
    endtask

    task automatic t_hold(input longint exp_res, input bit exp_ovr);
        ain = 77;
        for (int i = 0; i < 30; i++) @(negedge clk);
        chk(result_o == exp_res, "R10", "result held while idle", result_o, exp_res);
        chk(ovr_o == exp_ovr, "R10", "flag held while idle", ovr_o, exp_ovr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_convert(100, T1, 0);          // R5, R11: comparator high before integration
        t_convert(0, T1, 0);            // R5: crossing on first reference cycle
        t_convert(1, T1, 0);
        t_convert(T1 - 1, T1, 0);       // R5: largest in-range count
        t_convert(200, 3 * T1, 0);      // R5: rounded-up count 67
        t_convert(T1, T1, 0);           // R6: no crossing in the last allowed cycle
        t_hold(1 << RB, 1);             // R10
        t_convert(40, T1, 1);           // R8: start ignored mid-conversion; R10 clears flag
        t_hold(40, 0);                  // R10
        t_convert(1000, T1, 0);         // R6: far above full scale
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R7 watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule